// File: doc/BRIEF.md
# GPIO Port Interrupt Event Controller

This block watches the already-synchronized input levels of one eight-pin port and turns selected pin activity into a single interrupt request. Each pin has an enable bit and a two-bit event type. The type picks one of four behaviours: no event, a falling edge, a rising edge, or a difference between the live pin level and the level captured when software last read the port data. Every pin event feeds one shared posted-interrupt bit. That bit reaches the request output only while a global GPIO mask bit is set.

Software reaches the block through a simple write port with a register select, and through a strobe that marks each read of the port data register. The posted bit can also be written. With the software-post enable clear, such a write can only clear the bit. With that enable set, the write can only post the bit. A pin whose drive mode is high-impedance analog never raises an event. The interrupt handler finds the source pin itself, so the block makes no choice between pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A pin's event type is {type-high bit, type-low bit}. 00 never fires, 01 fires on a 1-to-0 transition, 10 fires on a 0-to-1 transition, and 11 is change-from-read mode.
- R2: Edge events compare each pin with its own level one clock earlier, so an edge gives an event in exactly one cycle. The posted bit is set at the clock edge that samples that cycle, and the bit stays set until software clears it.
- R3: In change-from-read mode a pin raises an event in every cycle in which its level differs from the level captured at the last read strobe (captured value is 0 after reset). A read strobe captures the current levels and so re-arms the comparison.
- R4: Pin enable bit n (register select 0, data bit n) at 0 suppresses all events of pin n. At 1 it allows them.
- R5: A pin whose high-Z-analog flag is 1 produces no event in any mode.
- R6: Events of all pins are ORed into one hardware event, and that event sets the posted bit.
- R7: irq_o is 1 exactly when the posted bit and the global mask bit (register select 3, data bit 5) are both 1. A posted bit held while masked appears as soon as the mask is set.
- R8: Writes to the posted bit use register select 4, data bit 5. With the software-post enable at 0, writing 0 clears the bit and writing 1 has no effect.
- R9: The software-post enable is register select 5, data bit 7. While it is 1, writing 1 to the posted bit sets it and writing 0 has no effect.
- R10: When a hardware event and a clearing write fall in the same cycle, the posted bit is left set.
- R11: After reset all enables, event types, mask and software-post enable are 0. The posted bit is 0 and irq_o is 0. Event-type bits are written with select 1 (low bit, data bit n) and select 2 (high bit, data bit n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Synchronized pin levels |
| rd_stb | input | 1 | One-cycle pulse marking a read of the port data register |
| analog_i | input | 8 | Per-pin flag, 1 when the pin's drive mode is high-Z analog |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Merged GPIO interrupt request |

## Verification
The main sweep covers every pin. For each pin it tries all four event types, both values of the enable and the analog flag, and both directions of a transition, from a quiet state each time. This shows whether the right edge direction is decoded, whether gating reaches only the addressed pin, and whether the events of all pins merge. For the change-from-read cases the sweep goes on past the first event. It clears the posted bit without a read to show that the event persists, then issues a read and clears again to show that the comparison re-arms. For the edge cases it clears once to show that the event lasts a single cycle. Separate sequences walk the posted bit through every write and enable combination, with and without the mask. One more sequence lines up a pin edge with a clearing write in the same cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    RS_PINEN  = 3'd0,
    RS_TYPELO = 3'd1,
    RS_TYPEHI = 3'd2,
    RS_MASK   = 3'd3,
    RS_POST   = 3'd4,
    RS_SWEN   = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    EV_OFF  = 2'b00,
    EV_FALL = 2'b01,
    EV_RISE = 2'b10,
    EV_CFR  = 2'b11
  } ev_mode_e;

  // Raw event of one pin for a given type, before enable and analog gating.
  function automatic logic pin_event(input logic [1:0] mode, input logic cur,
                                     input logic prev, input logic snap);
    logic r;
    case (mode)
      EV_FALL: r = prev & ~cur;
      EV_RISE: r = ~prev & cur;
      EV_CFR:  r = cur ^ snap;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Next value of the posted bit. A hardware event always wins.
  function automatic logic post_next(input logic cur, input logic hw_evt,
                                     input logic wr_hit, input logic swen,
                                     input logic wbit);
    logic r;
    if (hw_evt)       r = 1'b1;
    else if (!wr_hit) r = cur;
    else if (swen)    r = cur | wbit;
    else              r = cur & wbit;
    return r;
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NPIN     = 8,
  parameter int DW       = 8,
  parameter int MASK_BIT = 5,
  parameter int SWEN_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [NPIN-1:0] en_q,
  output logic [NPIN-1:0] tlo_q,
  output logic [NPIN-1:0] thi_q,
  output logic            mask_q,
  output logic            swen_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      tlo_q  <= '0;
      thi_q  <= '0;
      mask_q <= 1'b0;
      swen_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        RS_PINEN:  en_q   <= wr_data[NPIN-1:0];
        RS_TYPELO: tlo_q  <= wr_data[NPIN-1:0];
        RS_TYPEHI: thi_q  <= wr_data[NPIN-1:0];
        RS_MASK:   mask_q <= wr_data[MASK_BIT];
        RS_SWEN:   swen_q <= wr_data[SWEN_BIT];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            rd_stb,
  input  logic [NPIN-1:0] analog_i,
  input  logic [NPIN-1:0] en_q,
  input  logic [NPIN-1:0] tlo_q,
  input  logic [NPIN-1:0] thi_q,
  output logic [NPIN-1:0] evt_vec
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic prev_q;
    logic snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        snap_q <= 1'b0;
      end else begin
        prev_q <= pin_i[g];
        if (rd_stb) snap_q <= pin_i[g];
      end
    end

    assign evt_vec[g] = en_q[g] & ~analog_i[g] &
                        pin_event({thi_q[g], tlo_q[g]}, pin_i[g], prev_q, snap_q);
  end

endmodule

// File: rtl/gpio_irq_post.sv
module gpio_irq_post
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_evt,
  input  logic wr_hit,
  input  logic swen_q,
  input  logic wbit,
  output logic posted_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) posted_q <= 1'b0;
    else        posted_q <= post_next(posted_q, any_evt, wr_hit, swen_q, wbit);
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN     = 8,
  parameter int DW       = 8,
  parameter int MASK_BIT = 5,
  parameter int POST_BIT = 5,
  parameter int SWEN_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            rd_stb,
  input  logic [NPIN-1:0] analog_i,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic            irq_o
);

  logic [NPIN-1:0] en_q, tlo_q, thi_q;
  logic            mask_q, swen_q;
  logic [NPIN-1:0] evt_vec;
  logic            any_evt;
  logic            wr_hit;
  logic            wbit;
  logic            posted_q;

  gpio_irq_cfg #(.NPIN(NPIN), .DW(DW), .MASK_BIT(MASK_BIT), .SWEN_BIT(SWEN_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .en_q(en_q), .tlo_q(tlo_q), .thi_q(thi_q), .mask_q(mask_q), .swen_q(swen_q)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rd_stb(rd_stb), .analog_i(analog_i),
    .en_q(en_q), .tlo_q(tlo_q), .thi_q(thi_q), .evt_vec(evt_vec)
  );

  assign any_evt = |evt_vec;
  assign wr_hit  = wr_en && (wr_sel == RS_POST);
  assign wbit    = wr_data[POST_BIT];

  gpio_irq_post u_post (
    .clk(clk), .rst_n(rst_n), .any_evt(any_evt), .wr_hit(wr_hit),
    .swen_q(swen_q), .wbit(wbit), .posted_q(posted_q)
  );

  assign irq_o = posted_q & mask_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] analog_i,
  input logic [NPIN-1:0] en_q,
  input logic [NPIN-1:0] evt_vec,
  input logic            any_evt,
  input logic            wr_hit,
  input logic            wbit,
  input logic            swen_q,
  input logic            mask_q,
  input logic            posted_q,
  input logic            irq_o
);

  // R6
  evt_posts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> posted_q);

  // R10
  evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_evt && wr_hit && !swen_q && !wbit) |=> posted_q);

  // R8
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_evt && wr_hit && !swen_q && !wbit) |=> !posted_q);

  // R8
  sw_set_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_evt && wr_hit && !swen_q && wbit) |=> $stable(posted_q));

  // R9
  sw_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && swen_q && wbit) |=> posted_q);

  // R9
  sw_zero_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_evt && wr_hit && swen_q && !wbit) |=> $stable(posted_q));

  // R5
  analog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec & analog_i) == '0);

  // R4
  enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec & ~en_q) == '0);

  // R7
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q && posted_q));

  // R2
  posted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_evt && !wr_hit) |=> $stable(posted_q));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .analog_i(analog_i), .en_q(en_q), .evt_vec(evt_vec),
  .any_evt(any_evt), .wr_hit(wr_hit), .wbit(wbit), .swen_q(swen_q),
  .mask_q(mask_q), .posted_q(posted_q), .irq_o(irq_o)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;

  localparam int NPIN = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pin_i = '0;
  logic            rd_stb = 1'b0;
  logic [NPIN-1:0] analog_i = '0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_sel = '0;
  logic [7:0]      wr_data = '0;
  logic            irq_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rd_stb(rd_stb), .analog_i(analog_i),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish (actual=timeout expected=done)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic got, input logic exp, input string req);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: irq_o actual=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  function automatic logic expect_evt(input int m, input logic en, input logic an,
                                      input logic from, input logic to);
    logic r;
    if (!en || an) return 1'b0;
    case (m)
      1: r = (from == 1'b1) && (to == 1'b0);
      2: r = (from == 1'b0) && (to == 1'b1);
      3: r = (from != to);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(irq_o, 1'b0, "R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_o, 1'b0, "R11 after reset");

    wr(3'd3, 8'h20);  // mask on

    // Main sweep: R1 R2 R3 R4 R5 R6
    for (int p = 0; p < NPIN; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 8; k++) begin
          logic en, an, v, ex;
          en = k[0]; an = k[1]; v = k[2];
          wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
          analog_i = '0;
          pin_i = '0; pin_i[p] = v;
          repeat (2) @(negedge clk);
          rd_pulse();
          wr(3'd5, 8'h00);
          wr(3'd4, 8'h00);
          analog_i[p] = an;
          wr(3'd2, 8'(m[1]) << p);
          wr(3'd1, 8'(m[0]) << p);
          wr(3'd0, 8'(en) << p);
          check(irq_o, 1'b0, "R1 quiet before transition");
          ex = expect_evt(m, en, an, v, ~v);
          pin_i[p] = ~v;
          @(negedge clk);
          if (an) check(irq_o, ex, "R5 analog pin");
          else if (!en) check(irq_o, ex, "R4 disabled pin");
          else check(irq_o, ex, "R1 R6 event type");
          if (ex && m == 3) begin
            wr(3'd4, 8'h00);
            check(irq_o, 1'b1, "R3 persists until read");
            rd_pulse();
            wr(3'd4, 8'h00);
            check(irq_o, 1'b0, "R3 read re-arms");
          end else if (ex) begin
            wr(3'd4, 8'h00);
            check(irq_o, 1'b0, "R2 single-cycle edge");
          end
        end
      end
    end

    // R6: two pins change together, one event merged
    wr(3'd0, 8'h00); analog_i = '0; pin_i = '0;
    repeat (2) @(negedge clk);
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h81); wr(3'd1, 8'h00); wr(3'd0, 8'h81);
    pin_i = 8'h81;
    @(negedge clk);
    check(irq_o, 1'b1, "R6 merged pins");

    // R10: edge and clearing write in the same cycle
    wr(3'd4, 8'h00);
    check(irq_o, 1'b0, "R10 setup clear");
    @(negedge clk);
    pin_i = 8'h80;            // falling on pin 0 is not enabled (rising type)
    pin_i[0] = 1'b1;
    pin_i = 8'h00;            // pin 7 falls: rising type, no event
    pin_i[0] = 1'b0;
    @(negedge clk);
    wr(3'd1, 8'h00); wr(3'd2, 8'h01); wr(3'd0, 8'h01);
    wr(3'd4, 8'h00);
    check(irq_o, 1'b0, "R10 quiet");
    @(negedge clk);
    pin_i[0] = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check(irq_o, 1'b1, "R10 event wins over clear");

    // R7 R8 R9 software posting and masking
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h80);
    wr(3'd4, 8'h20);
    check(irq_o, 1'b0, "R7 masked post hidden");
    wr(3'd3, 8'h20);
    check(irq_o, 1'b1, "R7 post appears on unmask");
    wr(3'd4, 8'h00);
    check(irq_o, 1'b1, "R9 write 0 ignored with enable");
    wr(3'd4, 8'hDF);
    check(irq_o, 1'b1, "R9 other bits ignored");
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h20);
    check(irq_o, 1'b1, "R8 write 1 ignored without enable");
    wr(3'd4, 8'hDF);
    check(irq_o, 1'b0, "R8 write 0 clears");
    wr(3'd4, 8'h20);
    check(irq_o, 1'b0, "R8 write 1 does not post");
    wr(3'd5, 8'h7F);
    wr(3'd4, 8'h20);
    check(irq_o, 1'b0, "R9 enable is bit 7 only");
    wr(3'd5, 8'h80);
    wr(3'd4, 8'h20);
    check(irq_o, 1'b1, "R9 write 1 posts");
    wr(3'd3, 8'hDF);
    check(irq_o, 1'b0, "R7 mask is bit 5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule